// File: doc/BRIEF.md
# Multi-File Rename Occupancy Tracker

This block counts how many rename mappings are held in each of several physical rename register files. The files may overlap. Each destination register reaches the block with a 32-bit membership mask, where bit f names file f. An allocate request takes one mapping in every file that the mask names. A release request returns one mapping to each of those files. File 0 is the base file and covers every architectural register, so the block always treats bit 0 of any mask as set. Each file has an elaboration-time limit. A limit of zero makes that file unbounded.

Dispatch logic uses a query port to ask whether an instruction's destinations fit. It presents up to NUM_DST destination masks with valid bits. For each file, the block adds up the demand from all valid destinations and compares that sum with the file's free room. The result is a refusal mask with one bit per file, registered, where all zeros means the whole request fits. Misuse sets a sticky error flag. Misuse means releasing into an empty file, or allocating into a bounded file that is already full.

The block holds only counters and the checks around them. The mask tables, value storage and dependency tracking are outside it.

Top module: `ren_map_tracker`

## Requirements
- R1: After synchronous reset, every file count is 0, `qry_busy` is 0 and `err_flag` is 0.
- R2: Bit 0 is treated as set in every allocate mask, every release mask and every valid query mask. Mask bits at position NUM_FILES and above have no effect on counts or on the query result.
- R3: An accepted allocate raises the count of every file named by the mask by exactly one. When files overlap, several counts rise in the same cycle.
- R4: A release lowers by one the count of each named file whose count is non-zero.
- R5: A release naming a file whose count is 0 leaves that file's count unchanged, still lowers the other named files, and sets `err_flag` on the next edge.
- R6: An allocate that names a bounded file whose count equals its limit is refused as a whole. No count changes because of it, and `err_flag` is set. The count of a bounded file never exceeds its limit.
- R7: When an allocate and a release arrive in the same cycle, each file takes the net change. Acceptance and underflow are judged on the counts held before that edge.
- R8: A file with limit 0 never refuses an allocate and never shows in `qry_busy`. Its count saturates at 2^CNT_W-1.
- R9: In `qry_busy`, bit f is set when file f is bounded and the number of valid query destinations naming f exceeds limit minus count. The value is computed from the counts held before the edge and appears the cycle after the query. Bits at NUM_FILES and above are always 0.
- R10: `err_flag` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | 1 | Allocate request |
| alloc_mask | input | 32 | File membership of the allocated register |
| rel_vld | input | 1 | Release request |
| rel_mask | input | 32 | File membership of the released register |
| qry_vld | input | NUM_DST | Valid bit per query destination |
| qry_masks | input | 32*NUM_DST | Membership masks of query destinations, destination d at bits [32d+31:32d] |
| qry_busy | output | 32 | Registered per-file refusal mask |
| file_used | output | NUM_FILES*CNT_W | Count of file f at bits [f*CNT_W +: CNT_W] |
| err_flag | output | 1 | Sticky misuse flag |

## Verification
The bench exercises overlapping masks, which must move several counts at once. A design that served only the lowest set bit would leave file 2 flat when a 0x6 mask is allocated. It allocates into a full file while also naming files with room, which catches a design that accepts part of the request and bumps the files that still had room. It releases into an empty file alongside a non-empty one, which separates a design that wraps a count to 255 from one that wrongly skips the whole release. It also drives an unbounded base file past its counter range and sends masks carrying only high bits. Either case would expose a wrapping counter or a design that forgets to force bit 0.

// File: rtl/ren_trk_pkg.sv
package ren_trk_pkg;
  localparam int MASK_W = 32;
  typedef logic [MASK_W-1:0] fmask_t;

  // The base file covers every register, so bit 0 is forced on.
  function automatic fmask_t with_base(fmask_t m);
    return m | fmask_t'(1);
  endfunction
endpackage

// File: rtl/ren_demand.sv
module ren_demand #(
  parameter int NUM_FILES = 4,
  parameter int NUM_DST   = 2,
  parameter int DEM_W     = 2
) (
  input  logic [NUM_DST-1:0]                      qry_vld,
  input  logic [NUM_DST*ren_trk_pkg::MASK_W-1:0]  qry_masks,
  output logic [NUM_FILES*DEM_W-1:0]              demand
);
  import ren_trk_pkg::*;

  always_comb begin
    demand = '0;
    for (int f = 0; f < NUM_FILES; f++) begin
      logic [DEM_W-1:0] acc;
      acc = '0;
      for (int d = 0; d < NUM_DST; d++) begin
        fmask_t m;
        m = with_base(qry_masks[d*MASK_W +: MASK_W]);
        if (qry_vld[d] && m[f]) acc = acc + DEM_W'(1);
      end
      demand[f*DEM_W +: DEM_W] = acc;
    end
  end
endmodule

// File: rtl/ren_file_ctr.sv
module ren_file_ctr #(
  parameter int                 CNT_W = 8,
  parameter int                 DEM_W = 2,
  parameter logic [CNT_W-1:0]   LIMIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_hit,
  input  logic             rel_hit,
  input  logic [DEM_W-1:0] demand,
  output logic [CNT_W-1:0] used,
  output logic             full,
  output logic             under,
  output logic             refuse
);
  localparam logic             BOUNDED = (LIMIT != '0);
  localparam logic [CNT_W-1:0] CMAX    = '1;
  localparam int               SUM_W   = ((CNT_W > DEM_W) ? CNT_W : DEM_W) + 1;

  logic [CNT_W-1:0] used_q;
  logic             inc, dec;
  logic [SUM_W-1:0] need;

  assign inc   = alloc_hit && !(!BOUNDED && used_q == CMAX);
  assign dec   = rel_hit && (used_q != '0);
  assign under = rel_hit && (used_q == '0);
  assign full  = BOUNDED && (used_q >= LIMIT);
  assign need  = SUM_W'(demand) + SUM_W'(used_q);
  assign refuse = BOUNDED && (need > SUM_W'(LIMIT));
  assign used  = used_q;

  always_ff @(posedge clk) begin
    if (rst)
      used_q <= '0;
    else if (inc && !dec)
      used_q <= used_q + CNT_W'(1);
    else if (dec && !inc)
      used_q <= used_q - CNT_W'(1);
  end

  assert_limit_R6: assert property (@(posedge clk) disable iff (rst)
    BOUNDED |-> (used_q <= LIMIT));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    (rel_hit && !alloc_hit && used_q == '0) |=> (used_q == '0));

  assert_saturate_R8: assert property (@(posedge clk) disable iff (rst)
    (!BOUNDED && alloc_hit && !rel_hit && used_q == CMAX) |=> (used_q == CMAX));

  assert_grow_R3: assert property (@(posedge clk) disable iff (rst)
    (alloc_hit && !rel_hit && used_q != CMAX) |=> (used_q == $past(used_q) + CNT_W'(1)));
endmodule

// File: rtl/ren_map_tracker.sv
module ren_map_tracker #(
  parameter int NUM_FILES = 4,
  parameter int CNT_W     = 8,
  parameter int NUM_DST   = 2,
  parameter logic [NUM_FILES*CNT_W-1:0] FILE_LIMITS = 32'h02_06_04_00
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    alloc_vld,
  input  logic [ren_trk_pkg::MASK_W-1:0]          alloc_mask,
  input  logic                                    rel_vld,
  input  logic [ren_trk_pkg::MASK_W-1:0]          rel_mask,
  input  logic [NUM_DST-1:0]                      qry_vld,
  input  logic [NUM_DST*ren_trk_pkg::MASK_W-1:0]  qry_masks,
  output logic [ren_trk_pkg::MASK_W-1:0]          qry_busy,
  output logic [NUM_FILES*CNT_W-1:0]              file_used,
  output logic                                    err_flag
);
  import ren_trk_pkg::*;

  localparam int DEM_W = $clog2(NUM_DST + 1);

  fmask_t                    a_eff, r_eff, busy_n, busy_q;
  logic [NUM_FILES-1:0]      full_v, under_v, refuse_v, alloc_hit, rel_hit;
  logic [NUM_FILES-1:0]      unbounded_v;
  logic [NUM_FILES*DEM_W-1:0] demand;
  logic                      alloc_ok, err_q;

  assign a_eff    = with_base(alloc_mask);
  assign r_eff    = with_base(rel_mask);
  assign alloc_ok = alloc_vld && ((a_eff[NUM_FILES-1:0] & full_v) == '0);
  assign alloc_hit = {NUM_FILES{alloc_ok}} & a_eff[NUM_FILES-1:0];
  assign rel_hit   = {NUM_FILES{rel_vld}}  & r_eff[NUM_FILES-1:0];

  ren_demand #(.NUM_FILES(NUM_FILES), .NUM_DST(NUM_DST), .DEM_W(DEM_W)) u_dem (
    .qry_vld   (qry_vld),
    .qry_masks (qry_masks),
    .demand    (demand)
  );

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    localparam logic [CNT_W-1:0] LIM = FILE_LIMITS[f*CNT_W +: CNT_W];
    assign unbounded_v[f] = (LIM == '0);
    ren_file_ctr #(.CNT_W(CNT_W), .DEM_W(DEM_W), .LIMIT(LIM)) u_ctr (
      .clk       (clk),
      .rst       (rst),
      .alloc_hit (alloc_hit[f]),
      .rel_hit   (rel_hit[f]),
      .demand    (demand[f*DEM_W +: DEM_W]),
      .used      (file_used[f*CNT_W +: CNT_W]),
      .full      (full_v[f]),
      .under     (under_v[f]),
      .refuse    (refuse_v[f])
    );
  end

  always_comb begin
    busy_n = '0;
    busy_n[NUM_FILES-1:0] = refuse_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= '0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      err_q  <= err_q | (alloc_vld && !alloc_ok) | (|under_v);
    end
  end

  assign qry_busy = busy_q;
  assign err_flag = err_q;

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);

  assert_refused_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (alloc_vld && !alloc_ok && !rel_vld) |=> ($stable(file_used) && err_flag));

  assert_unbounded_free_R8: assert property (@(posedge clk) disable iff (rst)
    (qry_busy[NUM_FILES-1:0] & unbounded_v) == '0);

  assert_underflow_err_R5: assert property (@(posedge clk) disable iff (rst)
    (|under_v) |=> err_flag);
endmodule

// File: tb/ren_map_tracker_tb_top.sv
module ren_map_tracker_tb_top;
  localparam int NF = 4;
  localparam int CW = 8;
  localparam int ND = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        alloc_vld, rel_vld;
  logic [31:0] alloc_mask, rel_mask;
  logic [ND-1:0] qry_vld;
  logic [ND*32-1:0] qry_masks;
  logic [31:0] qry_busy;
  logic [NF*CW-1:0] file_used;
  logic        err_flag;

  always #10 clk = ~clk;

  ren_map_tracker #(.NUM_FILES(NF), .CNT_W(CW), .NUM_DST(ND),
                    .FILE_LIMITS(32'h02_06_04_00)) dut_i (
    .clk(clk), .rst(rst), .alloc_vld(alloc_vld), .alloc_mask(alloc_mask),
    .rel_vld(rel_vld), .rel_mask(rel_mask), .qry_vld(qry_vld),
    .qry_masks(qry_masks), .qry_busy(qry_busy), .file_used(file_used),
    .err_flag(err_flag)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  int lim [NF] = '{0, 4, 6, 2};
  int m_used [NF];
  int m_busy;
  bit m_err;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "qry_busy", int'(qry_busy), m_busy);
    for (int f = 0; f < NF; f++)
      chk(tag, $sformatf("used[%0d]", f), int'(file_used[f*CW +: CW]), m_used[f]);
    chk(tag, "err_flag", int'(err_flag), int'(m_err));
  endtask

  task automatic model_edge();
    int am, rm, ok, inc, dec, dem;
    int nxt [NF];
    am = (alloc_mask | 1) & 32'hF;
    rm = (rel_mask | 1) & 32'hF;
    m_busy = 0;
    for (int f = 0; f < NF; f++) begin
      dem = 0;
      for (int d = 0; d < ND; d++)
        if (qry_vld[d] && (((qry_masks[d*32 +: 32] | 1) >> f) & 1)) dem++;
      if (lim[f] != 0 && dem > lim[f] - m_used[f]) m_busy |= (1 << f);
    end
    ok = alloc_vld;
    for (int f = 0; f < NF; f++)
      if (((am >> f) & 1) && lim[f] != 0 && m_used[f] >= lim[f]) ok = 0;
    if (alloc_vld && !ok) m_err = 1;
    for (int f = 0; f < NF; f++) begin
      inc = (ok && ((am >> f) & 1)) ? 1 : 0;
      if (lim[f] == 0 && m_used[f] == 255) inc = 0;
      dec = 0;
      if (rel_vld && ((rm >> f) & 1)) begin
        if (m_used[f] > 0) dec = 1; else m_err = 1;
      end
      nxt[f] = m_used[f] + inc - dec;
    end
    for (int f = 0; f < NF; f++) m_used[f] = nxt[f];
  endtask

  task automatic step(input string tag, input bit av, input int am, input bit rv, input int rm,
                      input bit [1:0] qv, input int q0, input int q1);
    alloc_vld = av; alloc_mask = am; rel_vld = rv; rel_mask = rm;
    qry_vld = qv; qry_masks = {32'(q1), 32'(q0)};
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic do_reset();
    rst = 1'b1; alloc_vld = 0; rel_vld = 0; alloc_mask = 0; rel_mask = 0;
    qry_vld = 0; qry_masks = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int f = 0; f < NF; f++) m_used[f] = 0;
    m_busy = 0; m_err = 0;
    compare_all("R1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // Phase A: underflow on file 3 next to a live file 1 (R5), then sticky flag (R10)
    step("R3", 1, 32'h2, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 32'hA, 0, 0, 0);
    repeat (3) step("R10", 0, 0, 0, 0, 0, 0, 0);

    // Phase B: overlapping allocates, queries, refusal, same-cycle net change
    do_reset();
    repeat (4) step("R3", 1, 32'h6, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 2'b11, 32'h2, 32'h4);
    step("R9", 0, 0, 0, 0, 2'b11, 32'h4, 32'h4);
    step("R9", 0, 0, 0, 0, 2'b11, 32'h8, 32'h8);
    step("R2", 0, 0, 0, 0, 2'b11, 32'h100, 32'h100);
    step("R9", 0, 0, 0, 0, 2'b01, 32'h2, 32'h0);
    step("R6", 1, 32'h6, 0, 0, 0, 0, 0);
    step("R7", 1, 32'h4, 1, 32'h2, 0, 0, 0);
    step("R7", 1, 32'h2, 1, 32'h2, 0, 0, 0);
    step("R4", 0, 0, 1, 32'h6, 0, 0, 0);

    // Phase C: unbounded base file saturates; only high mask bits given (R8, R2)
    do_reset();
    for (int i = 0; i < 260; i++) step("R8", 1, 32'h100, 0, 0, 2'b11, 32'h1, 32'h1);
    step("R8", 1, 32'h1, 1, 32'h1, 0, 0, 0);
    step("R2", 0, 0, 1, 32'h80000000, 0, 0, 0);

    // Phase D: mixed random traffic against the model (R3 R4 R7 R9)
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      step("R7", r[0], ($urandom & 32'hF) | (r[8] ? 32'h40 : 0), r[1] & r[2],
           $urandom & 32'hF, r[4:3], $urandom & 32'hF, $urandom & 32'hF);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule